// File: doc/BRIEF.md
# Asynchronous Serial Receive Unit with Shared Line-Status Flag

This block receives characters from an asynchronous serial line. The line input passes through a synchronizer and is then sampled under a sample-enable that runs at sixteen times the bit rate. Each character has a low start bit, eight data bits sent least significant bit first, and an optional ninth "extra" bit. The character is accepted on one high stop bit. Accepted characters go into a small first-in-first-out store. The host reads the oldest entry from the data outputs and removes it with a one-cycle read strobe.

The block keeps one status bit, `lineStatus`, whose meaning depends on the mode. In normal operation it reports a bad stop bit. While the `sleepMode` input is high it reports that the line moved. Entering sleep empties the store and clears the flags. A one-cycle configuration-write strobe also clears the status bit and the overrun flag.

When the store is full, a further character is discarded and the `overrun` flag is set.

Top module: `rxFrameUnit`

## Requirements
- R1: With `sampleTick` high every cycle, each bit lasts 16 cycles. A frame is start(0), eight data bits LSB first, then the extra bit only when `extraEn`=1, then stop. `rdData` shows the data byte. `rdExtra` shows the extra bit when `extraEn`=1 and reads 0 otherwise.
- R2: A low level on the line starts a frame only if the line is still low 8 sample ticks later. Otherwise the receiver goes back to idle and stores nothing.
- R3: A stop bit sampled low sets `lineStatus` to 1, and the character is not stored.
- R4: A correctly framed character clears `lineStatus`.
- R5: A `cfgWr` pulse clears `lineStatus`. An `rdStrobe` pulse leaves it unchanged.
- R6: After a framing error the receiver returns to start-bit search. A character whose start bit follows the line's return high is received intact.
- R7: A character is stored as soon as its first stop bit has been sampled high. A second stop bit from the sender is treated as idle line.
- R8: While `sleepMode`=1 no character is received, and any transition of the line sets `lineStatus`.
- R9: A rising edge of `sleepMode` empties the store and clears `lineStatus` and `overrun`.
- R10: The store holds 8 characters in arrival order. `dataReady` is 1 while it is not empty, and `rdStrobe` removes the oldest entry. After reset the store is empty and both flags are 0.
- R11: A character arriving while the store is full is dropped and sets `overrun`. A `cfgWr` pulse clears `overrun`.
- R12: If a framing error and a `cfgWr` pulse fall in the same cycle, `lineStatus` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sample enable at 16x the bit rate |
| rxLine | input | 1 | Serial line, idle high |
| extraEn | input | 1 | Expect a ninth (extra) bit in each frame |
| sleepMode | input | 1 | Shutdown mode |
| cfgWr | input | 1 | Configuration-write strobe |
| rdStrobe | input | 1 | Read strobe; removes the oldest entry |
| rdData | output | 8 | Data byte of the oldest entry (0 when empty) |
| rdExtra | output | 1 | Extra bit of the oldest entry |
| dataReady | output | 1 | Store not empty |
| lineStatus | output | 1 | Framing error (normal mode) or line activity (sleep mode) |
| overrun | output | 1 | A character was dropped because the store was full |

## Verification
The stop-bit check that sets `lineStatus` and the configuration write that clears it can fall in the same cycle. The bench provokes this by starting a frame with a low stop bit and, in parallel, raising `cfgWr` for exactly the cycle in which the stop bit is sampled. That cycle is 154 cycles after the falling start edge: two synchronizer cycles, one idle-to-start cycle, 7 count cycles and the remaining bit periods. The collision is judged correct when the flag reads 1 afterwards. The bench also checks that a configuration write on its own clears the flag.

// File: rtl/rxUnitPkg.sv
package rxUnitPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_e;

  typedef struct packed {
    logic shiftEn;   // take one data/extra bit into the shift register
    logic frameOk;   // stop bit sampled high
    logic frameBad;  // stop bit sampled low
    logic wipe;      // first cycle of sleep mode
  } rxStrobe_t;
endpackage

// File: rtl/rxUnitSync.sv
module rxUnitSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= din;
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxUnitCtrl.sv
module rxUnitCtrl
  import rxUnitPkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxS,
  input  logic      sleepMode,
  input  logic      extraEn,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  rxState_e         state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [BIT_W-1:0] bitCnt, nBit, lastBit;
  logic             sleepPrev;

  assign lastBit = extraEn ? BIT_W'(DATA_BITS) : BIT_W'(DATA_BITS - 1);

  always_comb begin
    nState = state;
    nCnt   = cnt;
    nBit   = bitCnt;
    strobe = '0;
    strobe.wipe = sleepMode & ~sleepPrev;
    if (sleepMode) begin
      nState = ST_IDLE;
      nCnt   = '0;
      nBit   = '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!rxS) begin
            nState = ST_START;
            nCnt   = '0;
          end
        end
        ST_START: begin
          if (cnt == MID_CNT) begin
            nCnt = '0;
            nBit = '0;
            nState = rxS ? ST_IDLE : ST_DATA;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST_CNT) begin
            strobe.shiftEn = 1'b1;
            nCnt = '0;
            if (bitCnt == lastBit) nState = ST_STOP;
            else                   nBit = bitCnt + 1'b1;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == LAST_CNT) begin
            nCnt   = '0;
            nState = ST_IDLE;
            if (rxS) strobe.frameOk  = 1'b1;
            else     strobe.frameBad = 1'b1;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitCnt    <= '0;
      sleepPrev <= 1'b0;
    end else begin
      state     <= nState;
      cnt       <= nCnt;
      bitCnt    <= nBit;
      sleepPrev <= sleepMode;
    end
  end

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick && cnt == MID_CNT && rxS) |=> state == ST_IDLE); // R2
  AST_ERR_TO_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameBad |=> state == ST_IDLE); // R6
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode |=> (state == ST_IDLE && !strobe.frameOk)); // R8
endmodule

// File: rtl/rxUnitData.sv
module rxUnitData
  import rxUnitPkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 rxS,
  input  logic                 sleepMode,
  input  logic                 extraEn,
  input  logic                 cfgWr,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdExtra,
  output logic                 dataReady,
  output logic                 lineStatus,
  output logic                 overrun
);
  localparam int WORD_W = DATA_BITS + 1;
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level;
  logic              full, empty, push, pop;
  logic              rxPrev, flagSet, flagClr;

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);
  assign push  = strobe.frameOk & ~full;
  assign pop   = rdStrobe & ~empty;
  assign word  = extraEn ? shiftReg : {1'b0, shiftReg[WORD_W-1:1]};

  assign flagSet = sleepMode ? (rxS != rxPrev) : strobe.frameBad;
  assign flagClr = cfgWr | strobe.frameOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      level      <= '0;
      overrun    <= 1'b0;
      lineStatus <= 1'b0;
      rxPrev     <= 1'b1;
    end else begin
      rxPrev <= rxS;
      if (strobe.wipe) begin
        shiftReg   <= '0;
        wrPtr      <= '0;
        rdPtr      <= '0;
        level      <= '0;
        overrun    <= 1'b0;
        lineStatus <= 1'b0;
      end else begin
        if (strobe.shiftEn) shiftReg <= {rxS, shiftReg[WORD_W-1:1]};
        if (push) wrPtr <= wrPtr + PTR_W'(1);
        if (pop)  rdPtr <= rdPtr + PTR_W'(1);
        case ({push, pop})
          2'b10:   level <= level + 1'b1;
          2'b01:   level <= level - 1'b1;
          default: level <= level;
        endcase
        if (strobe.frameOk && full) overrun <= 1'b1;
        else if (cfgWr)             overrun <= 1'b0;
        if (flagSet)      lineStatus <= 1'b1;
        else if (flagClr) lineStatus <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= word;
  end

  assign rdData    = empty ? '0 : mem[rdPtr][DATA_BITS-1:0];
  assign rdExtra   = empty ? 1'b0 : mem[rdPtr][DATA_BITS];
  assign dataReady = ~empty;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL); // R10
  AST_BAD_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameBad |=> lineStatus); // R3
  AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameOk |=> !lineStatus); // R4
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (lineStatus && rdStrobe && !cfgWr && !strobe.frameOk && !strobe.wipe) |=> lineStatus); // R5
  AST_ACTIVITY: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && !strobe.wipe && rxS != rxPrev) |=> lineStatus); // R8
  AST_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> (level == '0 && !overrun && !lineStatus)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameOk && full && !rdStrobe) |=> ($stable(level) && overrun)); // R11
endmodule

// File: rtl/rxFrameUnit.sv
module rxFrameUnit
  import rxUnitPkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 extraEn,
  input  logic                 sleepMode,
  input  logic                 cfgWr,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdExtra,
  output logic                 dataReady,
  output logic                 lineStatus,
  output logic                 overrun
);
  logic      rxS;
  rxStrobe_t strobe;

  rxUnitSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(rxLine), .dout(rxS)
  );

  rxUnitCtrl #(.OSR(OSR), .DATA_BITS(DATA_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .rxS(rxS),
    .sleepMode(sleepMode), .extraEn(extraEn), .strobe(strobe)
  );

  rxUnitData #(.DATA_BITS(DATA_BITS), .FIFO_DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxS(rxS),
    .sleepMode(sleepMode), .extraEn(extraEn), .cfgWr(cfgWr),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdExtra(rdExtra),
    .dataReady(dataReady), .lineStatus(lineStatus), .overrun(overrun)
  );
endmodule

// File: tb/rxFrameUnit_test.sv
module rxFrameUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 16;
  // row: [11] extra bit used, [10] extra bit value, [9] stop high, [8] two stop bits, [7:0] data
  localparam logic [11:0] VECS [0:5] = '{12'h255, 12'hEA3, 12'h00F, 12'h3C8, 12'hA00, 12'h0FF};

  logic       clk = 1'b0;
  logic       rstN, sampleTick, rxLine, extraEn, sleepMode, cfgWr, rdStrobe;
  logic [7:0] rdData;
  logic       rdExtra, dataReady, lineStatus, overrun;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxFrameUnit uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .extraEn(extraEn), .sleepMode(sleepMode), .cfgWr(cfgWr), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdExtra(rdExtra), .dataReady(dataReady),
    .lineStatus(lineStatus), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // caller is at a negedge; start edge goes out at once
  task automatic sendFrame(input logic [7:0] d, input logic useX, input logic xb,
                           input logic stopV, input logic twoStop);
    rxLine = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    if (useX) begin
      rxLine = xb;
      repeat (BIT_CYC) @(negedge clk);
    end
    rxLine = stopV;
    repeat (BIT_CYC) @(negedge clk);
    if (twoStop) begin
      rxLine = 1'b1;
      repeat (BIT_CYC) @(negedge clk);
    end
    rxLine = 1'b1;
  endtask

  task automatic pulseRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pulseCfg();
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic fillNine();
    for (int k = 0; k < 9; k++) begin
      sendFrame(8'(8'h11 * (k + 1)), 1'b0, 1'b0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; sampleTick = 1'b1; rxLine = 1'b1; extraEn = 1'b0;
    sleepMode = 1'b0; cfgWr = 1'b0; rdStrobe = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset dataReady", 16'(dataReady), 16'h0);
    check("R10 reset lineStatus", 16'(lineStatus), 16'h0);
    check("R10 reset overrun", 16'(overrun), 16'h0);

    // vector table: frame shapes and status outcomes (R1 R3 R4 R7)
    for (int v = 0; v < 6; v++) begin
      logic [11:0] row;
      row = VECS[v];
      extraEn = row[11];
      @(negedge clk);
      sendFrame(row[7:0], row[11], row[10], row[9], row[8]);
      repeat (24) @(negedge clk);
      if (row[9]) begin
        check("R1 frame stored", 16'(dataReady), 16'h1);
        check("R1 data and extra", 16'({rdExtra, rdData}), 16'({row[11] & row[10], row[7:0]}));
        check("R4 good frame clears lineStatus", 16'(lineStatus), 16'h0);
        pulseRead();
        check("R10 read empties store", 16'(dataReady), 16'h0);
      end else begin
        check("R3 bad stop not stored", 16'(dataReady), 16'h0);
        check("R3 bad stop sets lineStatus", 16'(lineStatus), 16'h1);
      end
    end
    extraEn = 1'b0;

    // R5: read keeps flag, config write clears it
    pulseRead();
    @(negedge clk);
    check("R5 read keeps lineStatus", 16'(lineStatus), 16'h1);
    pulseCfg();
    @(negedge clk);
    check("R5 cfgWr clears lineStatus", 16'(lineStatus), 16'h0);

    // R2: short low glitch is no start
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (200) @(negedge clk);
    check("R2 glitch stores nothing", 16'(dataReady), 16'h0);
    check("R2 glitch leaves lineStatus", 16'(lineStatus), 16'h0);

    // R6: bad frame, line high briefly, then a good frame
    sendFrame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    sendFrame(8'h96, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check("R6 frame after error received", 16'(dataReady), 16'h1);
    check("R6 frame after error data", 16'(rdData), 16'h96);
    check("R6 lineStatus cleared", 16'(lineStatus), 16'h0);
    pulseRead();

    // R7: stored after first stop bit, while second stop is still on the line
    fork
      sendFrame(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
      begin
        repeat (156) @(negedge clk);
        check("R7 stored during second stop", 16'(dataReady), 16'h1);
        check("R7 data", 16'(rdData), 16'h5A);
      end
    join
    pulseRead();
    repeat (4) @(negedge clk);

    // R12: framing error and cfgWr in the same cycle
    fork
      sendFrame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
      begin
        repeat (154) @(negedge clk);
        cfgWr = 1'b1;
        @(negedge clk);
        cfgWr = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    check("R12 error wins over cfgWr", 16'(lineStatus), 16'h1);
    pulseCfg();

    // R10 R11: fill beyond depth, drain in order
    fillNine();
    check("R11 overrun on ninth", 16'(overrun), 16'h1);
    for (int k = 0; k < 8; k++) begin
      check("R10 order", 16'(rdData), 16'(8'(8'h11 * (k + 1))));
      pulseRead();
    end
    check("R11 ninth dropped", 16'(dataReady), 16'h0);

    // R9: sleep entry wipes store and flags
    sendFrame(8'h24, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    sendFrame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check("R9 precondition lineStatus", 16'(lineStatus), 16'h1);
    check("R9 precondition dataReady", 16'(dataReady), 16'h1);
    sleepMode = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 sleep empties store", 16'(dataReady), 16'h0);
    check("R9 sleep clears lineStatus", 16'(lineStatus), 16'h0);
    check("R9 sleep clears overrun", 16'(overrun), 16'h0);

    // R8: activity in sleep, and no reception
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 transition sets activity", 16'(lineStatus), 16'h1);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    sendFrame(8'h77, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check("R8 no reception in sleep", 16'(dataReady), 16'h0);
    sleepMode = 1'b0;
    @(negedge clk);
    pulseCfg();
    @(negedge clk);
    check("R5 cfgWr clears after wake", 16'(lineStatus), 16'h0);
    sendFrame(8'h42, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check("R1 reception after wake", 16'(rdData), 16'h42);
    pulseRead();

    // R11: cfgWr clears overrun
    fillNine();
    check("R11 overrun set again", 16'(overrun), 16'h1);
    pulseCfg();
    @(negedge clk);
    check("R11 cfgWr clears overrun", 16'(overrun), 16'h0);
    check("R10 store still full", 16'(dataReady), 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule